// File: doc/BRIEF.md
# DDR4 Command/Address Decoder

This block watches a registered DDR4-style command/address bus and turns each clock's sample into one typed command plus the fields that go with it. It sits behind the pin registers of a memory model or a bus monitor. Each of the two ranks has its own active-low chip select, and the low one marks the target rank. Downstream logic reads a strobe, a three-bit command code and the decoded fields, all one clock after the bus was sampled.

The command pins do two jobs. When the activate pin is low, the three command strobes are high row-address bits. When it is high, they encode the other commands. On column commands and on precharge, address bits 10 and 12 carry per-command flags. A parameter picks a 17-bit (x4) or 16-bit (x8) row address.

Top module: `ddr4_cmd_decode`

## Requirements
- R1: While reset is low, and on the first edge after it, every output is zero.
- R2: A bus sample with both chip selects high produces cmd_vld = 0 and cs_clash = 0 on the next clock, and every field output is zero.
- R3: With exactly one chip select low, cmd_vld = 1 on the next clock and rank is 0 for cs0_n low and 1 for cs1_n low. bank_grp and bank copy bg and ba.
- R4: Both chip selects low in one sample gives cs_clash = 1 and cmd_vld = 0 on the next clock.
- R5: With act_n low the code is ACT (1), and row = {ras_n, cas_n, we_n, addr[13:0]}. This gives 17 bits for x4. For x8 the top bit is dropped, leaving {cas_n, we_n, addr[13:0]}.
- R6: With act_n high, {ras_n,cas_n,we_n} decodes as follows: 000 = MRS (6), 001 = REF (5), 010 = PRE (4), 100 = WR (3), 101 = RD (2), 111 = NOP (0).
- R7: The two remaining patterns with act_n high, 011 and 110, give the code ILLEGAL (7).
- R8: On RD or WR, auto_pre equals addr[10]. On every other command it is 0.
- R9: On RD or WR, burst_chop is 1 when addr[12] is low. On every other command it is 0.
- R10: On PRE, pre_all equals addr[10]. On every other command it is 0.
- R11: On RD or WR, col = addr[9:0]. On every other command col is 0. row is 0 except on ACT.
- R12: Outputs are registered: a sample taken at one rising edge is presented until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs0_n | input | 1 | Rank 0 chip select, active low |
| cs1_n | input | 1 | Rank 1 chip select, active low |
| act_n | input | 1 | Activate strobe, active low |
| ras_n | input | 1 | Command strobe / row bit 16 |
| cas_n | input | 1 | Command strobe / row bit 15 |
| we_n | input | 1 | Command strobe / row bit 14 |
| addr | input | 14 | Address bits 13..0 |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank within group |
| cmd_vld | output | 1 | A single-rank command was sampled |
| cmd_kind | output | 3 | Command code (see R6, R7) |
| rank | output | 1 | Target rank |
| bank_grp | output | 2 | Decoded bank group |
| bank | output | 2 | Decoded bank |
| row | output | ROW_W | Row address on ACT (17 for x4, 16 for x8) |
| col | output | 10 | Column on RD/WR |
| auto_pre | output | 1 | Auto precharge requested |
| burst_chop | output | 1 | Chopped burst requested |
| pre_all | output | 1 | Precharge applies to all banks |
| cs_clash | output | 1 | Both chip selects were low |

## Verification
The block keeps no state beyond one register stage. Any internal fault therefore shows at the ports exactly one clock after the offending sample. A misrouted strobe shows as a wrong cmd_kind or wrong high row bits on that cycle. A flag left set from a column command would show up on the next non-column command. The bench checks this by following each column command directly with other commands. A stuck chip-select term appears as a wrong rank, a missing strobe or a missing clash flag on the very next cycle.

// File: rtl/ddr4_cmd_decode.sv
module ddr4_cmd_decode #(
  parameter bit X8 = 1'b0,
  localparam int ROW_W = X8 ? 16 : 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs0_n,
  input  logic             cs1_n,
  input  logic             act_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [13:0]      addr,
  input  logic [1:0]       bg,
  input  logic [1:0]       ba,
  output logic             cmd_vld,
  output logic [2:0]       cmd_kind,
  output logic             rank,
  output logic [1:0]       bank_grp,
  output logic [1:0]       bank,
  output logic [ROW_W-1:0] row,
  output logic [9:0]       col,
  output logic             auto_pre,
  output logic             burst_chop,
  output logic             pre_all,
  output logic             cs_clash
);

  localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_RD = 3'd2, K_WR = 3'd3,
                         K_PRE = 3'd4, K_REF = 3'd5, K_MRS = 3'd6, K_ILL = 3'd7;

  wire one_sel = cs0_n ^ cs1_n;
  wire clash   = !cs0_n && !cs1_n;
  wire [16:0] row_full = {ras_n, cas_n, we_n, addr};

  logic [2:0] kind_c;
  always_comb begin
    if (!act_n) kind_c = K_ACT;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  kind_c = K_MRS;
        3'b001:  kind_c = K_REF;
        3'b010:  kind_c = K_PRE;
        3'b100:  kind_c = K_WR;
        3'b101:  kind_c = K_RD;
        3'b111:  kind_c = K_NOP;
        default: kind_c = K_ILL;
      endcase
    end
  end

  wire is_rw  = (kind_c == K_RD) || (kind_c == K_WR);
  wire is_act = (kind_c == K_ACT);
  wire is_pre = (kind_c == K_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld    <= 1'b0;
      cmd_kind   <= K_NOP;
      rank       <= 1'b0;
      bank_grp   <= '0;
      bank       <= '0;
      row        <= '0;
      col        <= '0;
      auto_pre   <= 1'b0;
      burst_chop <= 1'b0;
      pre_all    <= 1'b0;
      cs_clash   <= 1'b0;
    end else begin
      cmd_vld    <= one_sel;
      cs_clash   <= clash;
      cmd_kind   <= one_sel ? kind_c : K_NOP;
      rank       <= one_sel && cs0_n;
      bank_grp   <= one_sel ? bg : 2'b00;
      bank       <= one_sel ? ba : 2'b00;
      row        <= (one_sel && is_act) ? row_full[ROW_W-1:0] : '0;
      col        <= (one_sel && is_rw) ? addr[9:0] : '0;
      auto_pre   <= one_sel && is_rw && addr[10];
      burst_chop <= one_sel && is_rw && !addr[12];
      pre_all    <= one_sel && is_pre && addr[10];
    end
  end

  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs0_n && cs1_n) |=> (!cmd_vld && !cs_clash)); // R2
  AST_RANK_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cs0_n != cs1_n) |=> (cmd_vld && rank == $past(cs0_n))); // R3
  AST_CLASH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs0_n && !cs1_n) |=> (cs_clash && !cmd_vld)); // R4
  AST_ACT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs0_n != cs1_n) && !act_n) |=> (cmd_kind == K_ACT && row[13:0] == $past(addr))); // R5
  AST_AP_ONLY_RW: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (cmd_kind == K_RD || cmd_kind == K_WR)); // R8
  AST_BC_ONLY_RW: assert property (@(posedge clk) disable iff (!rst_n)
    burst_chop |-> (cmd_kind == K_RD || cmd_kind == K_WR)); // R9
  AST_PALL_ONLY_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |-> (cmd_vld && cmd_kind == K_PRE)); // R10

endmodule

// File: tb/ddr4_cmd_decode_tb.sv
module ddr4_cmd_decode_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs0_n = 1'b1, cs1_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [13:0] addr = '0;
  logic [1:0] bg = '0, ba = '0;
  logic cmd_vld, rank, auto_pre, burst_chop, pre_all, cs_clash;
  logic [2:0] cmd_kind;
  logic [1:0] bank_grp, bank;
  logic [16:0] row;
  logic [9:0] col;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ddr4_cmd_decode #(.X8(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .act_n(act_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .bg(bg), .ba(ba),
    .cmd_vld(cmd_vld), .cmd_kind(cmd_kind), .rank(rank), .bank_grp(bank_grp),
    .bank(bank), .row(row), .col(col), .auto_pre(auto_pre),
    .burst_chop(burst_chop), .pre_all(pre_all), .cs_clash(cs_clash));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic c0, input logic c1, input logic a, input logic [2:0] rcw,
                       input logic [13:0] ad, input logic [1:0] g, input logic [1:0] b);
    @(negedge clk);
    cs0_n = c0; cs1_n = c1; act_n = a; {ras_n, cas_n, we_n} = rcw;
    addr = ad; bg = g; ba = b;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 vld", cmd_vld, 0); chk("R1 kind", cmd_kind, 0);
    chk("R1 row", row, 0); chk("R1 clash", cs_clash, 0);
  endtask

  task automatic t_idle;
    issue(1, 1, 0, 3'b000, 14'h3fff, 2'd3, 2'd3);
    chk("R2 vld", cmd_vld, 0); chk("R2 clash", cs_clash, 0);
    chk("R2 row", row, 0); chk("R2 grp", bank_grp, 0);
  endtask

  task automatic t_act;
    issue(0, 1, 0, 3'b101, 14'h1234, 2'd2, 2'd1);
    chk("R5 kind", cmd_kind, 1); chk("R5 row", row, {3'b101, 14'h1234});
    chk("R3 vld", cmd_vld, 1); chk("R3 rank", rank, 0);
    chk("R3 grp", bank_grp, 2); chk("R3 bank", bank, 1);
    chk("R11 col on act", col, 0);
    issue(1, 0, 0, 3'b010, 14'h0001, 2'd0, 2'd3);
    chk("R3 rank1", rank, 1); chk("R5 row2", row, {3'b010, 14'h0001});
  endtask

  task automatic t_rw;
    issue(0, 1, 1, 3'b101, 14'b00_0100_1010_1010, 2'd1, 2'd2);
    chk("R6 rd", cmd_kind, 2); chk("R8 ap", auto_pre, 1);
    chk("R9 bc", burst_chop, 1); chk("R11 col", col, 10'h0aa);
    chk("R11 row on rd", row, 0); chk("R12 hold", cmd_kind, 2);
    issue(1, 0, 1, 3'b100, 14'b01_0000_0011_0011, 2'd0, 2'd0);
    chk("R6 wr", cmd_kind, 3); chk("R8 no ap", auto_pre, 0);
    chk("R9 full", burst_chop, 0); chk("R11 col wr", col, 10'h033);
    issue(0, 1, 1, 3'b001, 14'h3fff, 2'd0, 2'd0);
    chk("R6 ref", cmd_kind, 5); chk("R8 ref ap", auto_pre, 0);
    chk("R9 ref bc", burst_chop, 0); chk("R10 ref pall", pre_all, 0);
    chk("R11 ref col", col, 0);
  endtask

  task automatic t_pre;
    issue(0, 1, 1, 3'b010, 14'h0400, 2'd1, 2'd1);
    chk("R6 pre", cmd_kind, 4); chk("R10 all", pre_all, 1);
    chk("R8 pre ap", auto_pre, 0);
    issue(0, 1, 1, 3'b010, 14'h0000, 2'd3, 2'd2);
    chk("R10 single", pre_all, 0); chk("R10 grp", bank_grp, 3); chk("R10 bank", bank, 2);
  endtask

  task automatic t_misc;
    issue(0, 1, 1, 3'b000, 14'h0400, 2'd0, 2'd0);
    chk("R6 mrs", cmd_kind, 6); chk("R10 mrs pall", pre_all, 0);
    issue(0, 1, 1, 3'b111, 14'h0000, 2'd0, 2'd0);
    chk("R6 nop", cmd_kind, 0); chk("R6 nop vld", cmd_vld, 1);
    issue(0, 1, 1, 3'b011, 14'h0000, 2'd0, 2'd0);
    chk("R7 ill011", cmd_kind, 7);
    issue(1, 0, 1, 3'b110, 14'h0000, 2'd0, 2'd0);
    chk("R7 ill110", cmd_kind, 7);
  endtask

  task automatic t_clash;
    issue(0, 0, 0, 3'b111, 14'h3fff, 2'd1, 2'd1);
    chk("R4 clash", cs_clash, 1); chk("R4 vld", cmd_vld, 0); chk("R4 row", row, 0);
    issue(1, 1, 1, 3'b111, 14'h0, 2'd0, 2'd0);
    chk("R4 clears", cs_clash, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle(); t_act(); t_rw(); t_pre(); t_misc(); t_clash();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule